// File: doc/BRIEF.md
# Snapshot Event Counter Peripheral

This block sits on a simple synchronous byte bus and keeps four free-running 64-bit counters fed by a CPU core: elapsed clock cycles, retired instructions, accepted IRQs and accepted NMIs. It does not let software read a live counter directly. Software first writes any value to a trigger location. That write freezes all four counters and the current 64-bit wall-time input into a bank of snapshot registers in one clock. Software then picks one snapshot with a selector register and reads it a byte at a time through an eight-byte window.

The block decodes its own ten-byte address range. It raises `hit_o` so that the bus fabric sends accesses outside the range to ordinary memory. Read data is registered.

Top module: `snap_counter_periph`

## Requirements
- R1: `hit_o` is high exactly when `addr_i` lies in 0xFFC0..0xFFC9 inclusive. A read outside that range gives `rdata_o` = 0 in the following cycle.
- R2: A write of any data to offset 0 (0xFFC0) copies the four live counters and `wall_time_i` into the snapshots on that clock edge. If a counter event arrives in the same cycle, the snapshot holds the count from before that increment. Snapshots do not change at any other time.
- R3: Offset 1 (0xFFC1) is an 8-bit selector. A write stores `wdata_i`, and a read returns the stored value.
- R4: Offsets 2..9 return the selected 64-bit snapshot in little-endian order. Offset 2 returns bits 7:0 and offset 9 returns bits 63:56.
- R5: Selector code 0x00 picks the cycle count, 0x01 the instruction count, 0x02 the IRQ count, 0x03 the NMI count and 0x80 the wall time.
- R6: With any other selector value, all eight window bytes read as zero.
- R7: A read of offset 0 returns zero. A write to offsets 2..9, or to any address outside the range, changes neither the selector nor any snapshot.
- R8: When `cyc_valid_i` is high, the cycle counter adds the 4-bit `cyc_cnt_i`. Otherwise it holds its value.
- R9: The instruction, IRQ and NMI counters each add one in every cycle where their pulse input is high. An interrupt pulse does not move the instruction counter.
- R10: An asynchronous reset (`rst_ni` low) clears all live counters, all snapshots, the selector and `rdata_o`.
- R11: Read data appears on `rdata_o` in the cycle after `rd_i` is sampled. In every cycle after one with no read inside the range, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| hit_o | output | 1 | Address falls inside the peripheral range |
| cyc_valid_i | input | 1 | Cycle increment is valid |
| cyc_cnt_i | input | 4 | Cycle cost of the executed step |
| insn_i | input | 1 | One instruction retired |
| irq_i | input | 1 | One IRQ accepted |
| nmi_i | input | 1 | One NMI accepted |
| wall_time_i | input | 64 | Current wall time |

## Verification
Live counters cannot be seen at the ports. A wrong increment in one of them therefore shows up only at the next trigger write, and then only as a wrong byte in the window when its code is selected. To expose such an error within a few cycles of any latch, the bench runs a cycle-accurate reference model and reads every window byte under every defined code, as well as several undefined ones. A fault in the selector or in the byte steering shows up on the very next read. A snapshot taken in the same cycle as an event must match the count from before that event.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
package snap_pkg;
  localparam int NUM_SRC  = 5;
  localparam int SRC_CYC  = 0;
  localparam int SRC_INS  = 1;
  localparam int SRC_IRQ  = 2;
  localparam int SRC_NMI  = 3;
  localparam int SRC_WALL = 4;

  localparam logic [7:0] CODE_CYC  = 8'h00;
  localparam logic [7:0] CODE_INS  = 8'h01;
  localparam logic [7:0] CODE_IRQ  = 8'h02;
  localparam logic [7:0] CODE_NMI  = 8'h03;
  localparam logic [7:0] CODE_WALL = 8'h80;

  localparam int OFF_TRIG = 0;
  localparam int OFF_SEL  = 1;
  localparam int OFF_WIN  = 2;
endpackage

// File: rtl/snap_evt_counter.sv
`timescale 1ns/1ps
module snap_evt_counter #(
  parameter int W     = 64,
  parameter int INC_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + W'(inc_i);  // wraps modulo 2^W
  end

  assign cnt_o = cnt_q;

  // R8 / R9: each enabled cycle adds the increment
  p_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_o == $past(cnt_o) + W'($past(inc_i)));
  p_count_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o));
endmodule

// File: rtl/snap_latch_bank.sv
`timescale 1ns/1ps
module snap_latch_bank #(
  parameter int W = 64,
  parameter int N = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic [N-1:0][W-1:0] live_i,
  output logic [N-1:0][W-1:0] snap_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    slot_q <= '0;
      else if (cap_i) slot_q <= live_i[g];
    end
    assign snap_o[g] = slot_q;
  end

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> snap_o == $past(live_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(snap_o));
endmodule

// File: rtl/snap_read_port.sv
`timescale 1ns/1ps
module snap_read_port
  import snap_pkg::*;
#(
  parameter int W     = 64,
  parameter int N     = NUM_SRC,
  parameter int OFF_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [7:0]          wdata_i,
  input  logic [N-1:0][W-1:0] snap_i,
  output logic [7:0]          rdata_o
);
  localparam int WIN_BYTES = W / 8;
  localparam int IDX_W     = $clog2(WIN_BYTES);

  logic [7:0]       sel_q;
  logic [7:0]       rdata_q;
  logic [W-1:0]     chosen;
  logic [IDX_W-1:0] byte_idx;
  logic [7:0]       rd_nxt;
  logic             sel_wr, rd_hit;

  assign sel_wr   = wr_i && hit_i && (off_i == OFF_W'(OFF_SEL));
  assign rd_hit   = rd_i && hit_i;
  assign byte_idx = IDX_W'(off_i - OFF_W'(OFF_WIN));

  always_comb begin
    case (sel_q)
      CODE_CYC:  chosen = snap_i[SRC_CYC];
      CODE_INS:  chosen = snap_i[SRC_INS];
      CODE_IRQ:  chosen = snap_i[SRC_IRQ];
      CODE_NMI:  chosen = snap_i[SRC_NMI];
      CODE_WALL: chosen = snap_i[SRC_WALL];
      default:   chosen = '0;
    endcase
  end

  always_comb begin
    rd_nxt = 8'h00;
    if (off_i == OFF_W'(OFF_SEL))
      rd_nxt = sel_q;
    else if (off_i >= OFF_W'(OFF_WIN) && off_i < OFF_W'(OFF_WIN + WIN_BYTES))
      rd_nxt = chosen[8*byte_idx +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      if (sel_wr) sel_q <= wdata_i;
      rdata_q <= rd_hit ? rd_nxt : 8'h00;
    end
  end

  assign rdata_o = rdata_q;

  p_sel_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr |=> $stable(sel_q));
  p_sel_readback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit && off_i == OFF_W'(OFF_SEL) |=> rdata_o == $past(sel_q));
  p_trig_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit && off_i == OFF_W'(OFF_TRIG) |=> rdata_o == 8'h00);
  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> rdata_o == 8'h00);
endmodule

// File: rtl/snap_counter_periph.sv
`timescale 1ns/1ps
module snap_counter_periph
  import snap_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'hFFC0,
  parameter int          CNT_W     = 64,
  parameter int          CYC_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [7:0]       rdata_o,
  output logic             hit_o,
  input  logic             cyc_valid_i,
  input  logic [CYC_W-1:0] cyc_cnt_i,
  input  logic             insn_i,
  input  logic             irq_i,
  input  logic             nmi_i,
  input  logic [CNT_W-1:0] wall_time_i
);
  localparam int          WIN_BYTES = CNT_W / 8;
  localparam int          SPAN      = OFF_WIN + WIN_BYTES;
  localparam int          OFF_W     = $clog2(SPAN);
  localparam logic [15:0] LAST_ADDR = BASE_ADDR + 16'(SPAN - 1);

  logic [OFF_W-1:0]               off;
  logic                           cap;
  logic [NUM_SRC-1:0][CNT_W-1:0]  live;
  logic [NUM_SRC-1:0][CNT_W-1:0]  snap;
  logic [NUM_SRC-2:0]             ev_en;
  logic [NUM_SRC-2:0][CYC_W-1:0]  ev_inc;

  assign hit_o = (addr_i >= BASE_ADDR) && (addr_i <= LAST_ADDR);
  assign off   = OFF_W'(addr_i - BASE_ADDR);
  assign cap   = wr_i && hit_o && (off == OFF_W'(OFF_TRIG));

  assign ev_en[SRC_CYC]  = cyc_valid_i;
  assign ev_inc[SRC_CYC] = cyc_cnt_i;
  assign ev_en[SRC_INS]  = insn_i;
  assign ev_inc[SRC_INS] = CYC_W'(1);
  assign ev_en[SRC_IRQ]  = irq_i;
  assign ev_inc[SRC_IRQ] = CYC_W'(1);
  assign ev_en[SRC_NMI]  = nmi_i;
  assign ev_inc[SRC_NMI] = CYC_W'(1);

  for (genvar g = 0; g < NUM_SRC - 1; g++) begin : g_cnt
    snap_evt_counter #(.W(CNT_W), .INC_W(CYC_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ev_en[g]),
      .inc_i  (ev_inc[g]),
      .cnt_o  (live[g])
    );
  end
  assign live[SRC_WALL] = wall_time_i;

  snap_latch_bank #(.W(CNT_W), .N(NUM_SRC)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .live_i (live),
    .snap_o (snap)
  );

  snap_read_port #(.W(CNT_W), .N(NUM_SRC), .OFF_W(OFF_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit_o),
    .off_i   (off),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wdata_i (wdata_i),
    .snap_i  (snap),
    .rdata_o (rdata_o)
  );

  p_outside_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !hit_o |=> rdata_o == 8'h00);
  p_insn_not_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_i |=> $stable(live[SRC_INS]));
endmodule

// File: tb/snap_counter_periph_bench.sv
`timescale 1ns/1ps
module snap_counter_periph_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic        hit;
  logic        cyc_v = 1'b0;
  logic [3:0]  cyc_n = 4'h0;
  logic        ins = 1'b0, irq = 1'b0, nmi = 1'b0;
  logic [63:0] wall = 64'h0;

  always #10 clk = ~clk;  // 50 MHz

  snap_counter_periph u_snap_counter_periph (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .hit_o(hit), .cyc_valid_i(cyc_v), .cyc_cnt_i(cyc_n),
    .insn_i(ins), .irq_i(irq), .nmi_i(nmi), .wall_time_i(wall)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R10";
  bit    ev_rand = 1'b0;
  longint unsigned last_wall;

  // reference model
  longint unsigned m_live[4];
  longint unsigned m_snap[5];
  logic [7:0]      m_sel, m_rdata;

  function automatic bit in_win(logic [15:0] a);
    return a >= 16'hFFC0 && a <= 16'hFFC9;
  endfunction

  function automatic logic [7:0] m_read(logic [15:0] a);
    int off;
    longint unsigned v;
    if (!in_win(a)) return 8'h00;
    off = int'(a - 16'hFFC0);
    if (off == 1) return m_sel;
    if (off < 2) return 8'h00;
    case (m_sel)
      8'h00: v = m_snap[0];
      8'h01: v = m_snap[1];
      8'h02: v = m_snap[2];
      8'h03: v = m_snap[3];
      8'h80: v = m_snap[4];
      default: v = 0;
    endcase
    return 8'((v >> (8 * (off - 2))) & 64'hFF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_live[i] <= 0;
      for (int i = 0; i < 5; i++) m_snap[i] <= 0;
      m_sel <= 8'h00;
      m_rdata <= 8'h00;
    end else begin
      if (wr && addr == 16'hFFC0) begin
        for (int i = 0; i < 4; i++) m_snap[i] <= m_live[i];
        m_snap[4] <= wall;
      end
      if (wr && addr == 16'hFFC1) m_sel <= wdata;
      if (cyc_v) m_live[0] <= m_live[0] + longint'(cyc_n);
      if (ins)   m_live[1] <= m_live[1] + 1;
      if (irq)   m_live[2] <= m_live[2] + 1;
      if (nmi)   m_live[3] <= m_live[3] + 1;
      m_rdata <= rd ? m_read(addr) : 8'h00;
    end
  end

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the edge
  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      check(cur_req, rdata, m_rdata);
      check("R1", hit, in_win(addr));
    end
  end

  task automatic set_bus(logic [15:0] a, logic w, logic r, logic [7:0] d);
    addr = a; wr = w; rd = r; wdata = d;
    wall = wall + 64'h9E37_79B9_7F4A_7C15;
    last_wall = wall;
    if (ev_rand) begin
      cyc_v = 1'($urandom); cyc_n = 4'($urandom);
      ins = 1'($urandom); irq = ($urandom % 5) == 0; nmi = ($urandom % 9) == 0;
    end
  endtask

  task automatic drive(logic [15:0] a, logic w, logic r, logic [7:0] d);
    set_bus(a, w, r, d);
    @(negedge clk);
  endtask

  task automatic rd_expect(logic [15:0] a, logic [7:0] exp, string req);
    set_bus(a, 1'b0, 1'b1, 8'h00);
    @(posedge clk);
    #5;
    check(req, rdata, exp);
    @(negedge clk);
  endtask

  task automatic evt(logic cv, logic [3:0] cn, logic i, logic q, logic n);
    cyc_v = cv; cyc_n = cn; ins = i; irq = q; nmi = n;
    drive(16'h1234, 1'b0, 1'b0, 8'h00);
    cyc_v = 0; cyc_n = 0; ins = 0; irq = 0; nmi = 0;
  endtask

  task automatic read_all(logic [7:0] code);
    drive(16'hFFC1, 1'b1, 1'b0, code);
    for (int o = 0; o < 10; o++) drive(16'hFFC0 + 16'(o), 1'b0, 1'b1, 8'h00);
    drive(16'hFFBF, 1'b0, 1'b1, 8'h00);
    drive(16'hFFCA, 1'b0, 1'b1, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [63:0] w_snap;
  logic [7:0]  codes[9] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h80, 8'h04, 8'h7F, 8'h81, 8'hFF};

  initial begin
    repeat (3) @(negedge clk);
    check("R10", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: everything reads zero after reset
    cur_req = "R10";
    rd_expect(16'hFFC1, 8'h00, "R10");
    rd_expect(16'hFFC2, 8'h00, "R10");
    read_all(8'h80);

    // R8/R9 directed counts
    cur_req = "R8";
    drive(16'hFFC1, 1'b1, 1'b0, 8'h00);
    for (int k = 0; k < 3; k++) evt(1, 4'd5, 0, 0, 0);
    evt(1, 4'd15, 0, 0, 0);
    for (int k = 0; k < 4; k++) evt(0, 0, 1, 0, 0);
    evt(0, 0, 0, 1, 0);
    evt(0, 0, 0, 1, 1);
    drive(16'hFFC0, 1'b1, 1'b0, 8'h5A);
    w_snap = last_wall;
    rd_expect(16'hFFC2, 8'd30, "R8");
    rd_expect(16'hFFC3, 8'd0, "R4");
    drive(16'hFFC1, 1'b1, 1'b0, 8'h01);
    rd_expect(16'hFFC2, 8'd4, "R9");
    drive(16'hFFC1, 1'b1, 1'b0, 8'h02);
    rd_expect(16'hFFC2, 8'd2, "R9");
    drive(16'hFFC1, 1'b1, 1'b0, 8'h03);
    rd_expect(16'hFFC2, 8'd1, "R9");
    drive(16'hFFC1, 1'b1, 1'b0, 8'h80);
    rd_expect(16'hFFC1, 8'h80, "R3");
    for (int b = 0; b < 8; b++)
      rd_expect(16'hFFC2 + 16'(b), w_snap[8*b +: 8], "R4");
    drive(16'hFFC1, 1'b1, 1'b0, 8'h05);
    rd_expect(16'hFFC9, 8'h00, "R6");
    rd_expect(16'hFFC0, 8'h00, "R7");
    rd_expect(16'h0000, 8'h00, "R1");

    // random event traffic, then every code
    cur_req = "R8";
    ev_rand = 1'b1;
    repeat (300) drive(16'h0200, 1'b0, 1'b0, 8'h00);
    drive(16'hFFC0, 1'b1, 1'b0, 8'h00);
    foreach (codes[i]) begin
      cur_req = (i < 5) ? "R5" : "R6";
      read_all(codes[i]);
    end

    // R7: ignored writes
    cur_req = "R7";
    drive(16'hFFC1, 1'b1, 1'b0, 8'h02);
    for (int o = 2; o < 10; o++) drive(16'hFFC0 + 16'(o), 1'b1, 1'b0, 8'hC3);
    drive(16'hFFBF, 1'b1, 1'b0, 8'h00);
    drive(16'hFFCA, 1'b1, 1'b0, 8'h00);
    rd_expect(16'hFFC1, 8'h02, "R7");
    read_all(8'h02);

    // R2: latch alongside events
    cur_req = "R2";
    for (int k = 0; k < 20; k++) begin
      repeat (7) drive(16'h0300, 1'b0, 1'b0, 8'h00);
      drive(16'hFFC0, 1'b1, 1'b0, 8'hFF);
      read_all(8'(k % 4));
    end
    ev_rand = 1'b0;
    drive(16'hFFC0, 1'b1, 1'b0, 8'h00);
    evt(1, 4'd9, 1, 1, 1);  // counters move, snapshot must not
    rd_expect(16'hFFC2, m_read(16'hFFC2), "R2");

    // R11: idle cycles read zero
    cur_req = "R11";
    repeat (10) drive(16'hFFC2, 1'b0, 1'b0, 8'h00);
    rd_expect(16'hFFC1, 8'h03, "R11");

    // R10: reset in mid-run
    ev_rand = 1'b1;
    repeat (20) drive(16'h0400, 1'b0, 1'b0, 8'h00);
    drive(16'hFFC0, 1'b1, 1'b0, 8'h00);
    ev_rand = 1'b0;
    cyc_v = 0; ins = 0; irq = 0; nmi = 0;
    #3 rst_n = 1'b0;
    #1 check("R10", rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R10";
    rd_expect(16'hFFC1, 8'h00, "R10");
    drive(16'hFFC0, 1'b1, 1'b0, 8'h00);
    rd_expect(16'hFFC2, 8'h00, "R10");
    read_all(8'h03);

    drive(16'h0000, 1'b0, 1'b0, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule